// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block is the add and subtract slice of an accumulator-style datapath. On a start strobe it takes the accumulator value, an operand, an incoming carry, an operation select and a decimal-mode bit. It then registers a result together with the negative (N), overflow (V), zero (Z) and carry (C) flags. The result and flags become visible on the clock edge that samples the strobe, and a one-cycle done pulse marks them as new.

In binary mode it is a plain two's-complement adder. For subtraction the incoming carry acts as an inverted borrow. In decimal mode each 4-bit digit is corrected by 6 whenever it leaves the 0..9 range. The flags then come from mixed sources:
- Decimal add takes Z from the uncorrected binary sum.
- Decimal add takes N and V from the top digit before its correction.
- Decimal add takes C from the top digit after its correction.
- Decimal subtract takes every flag from the binary difference.

Digits above 9 are not rejected. They pass through the same correction steps. The number of digits is a parameter, and the default of two gives an 8-bit datapath.

Top module: `addsub_unit`

## Requirements
- R1: While reset is asserted and after it is released, result, all four flags and done are 0 until the first start.
- R2: A start sampled at a clock edge updates result and flags at that edge, and done is 1 for exactly the following cycle. Without start, result and flags hold their values and done is 0.
- R3: Binary add (op_sub=0, dec_mode=0) gives result = (A + B + carry_in) mod 2^W. flag_c is 1 when A + B + carry_in exceeds 2^W - 1.
- R4: In binary mode, flag_n equals result bit W-1 and flag_z is 1 when result is 0. For add, flag_v is 1 when A and B share the sign bit and result's sign differs from A's.
- R5: Binary subtract (op_sub=1, dec_mode=0) gives result = (A - B - (1 - carry_in)) mod 2^W. flag_c is 1 when no borrow occurs, that is when A >= B + (1 - carry_in). flag_v is 1 when A and B differ in sign and result's sign differs from A's.
- R6: Decimal add (op_sub=0, dec_mode=1) forms each digit sum, where digit i is bits 4i+3..4i and digit 0 includes carry_in. A sum above 9 has 6 added. A digit carries into the next digit when its corrected sum exceeds 15. The result digit is the low 4 bits of the corrected sum.
- R7: In decimal add, flag_c is 1 when the corrected top-digit sum exceeds 15.
- R8: In decimal add, flag_z is 1 when the binary sum (A + B + carry_in) mod 2^W is 0. flag_n is bit 3 of the top-digit sum before correction. flag_v is 1 when that bit differs from A's sign bit and A and B share the sign bit.
- R9: Decimal subtract (op_sub=1, dec_mode=1) forms each digit difference, with the borrow from the digit below (digit 0 uses 1 - carry_in). When the difference is negative, 6 more is subtracted and a borrow passes upward. The result digit is the low 4 bits.
- R10: In decimal subtract, flag_c, flag_v, flag_n and flag_z equal those of the binary subtraction of the same inputs.
- R11: Digits from 10 to 15 in either input go through the same correction arithmetic, with no special handling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe, sampled at the rising edge |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed decimal arithmetic |
| carry_in | input | 1 | Incoming carry (inverted borrow for subtract) |
| acc_in | input | 4*DIGITS | Accumulator operand A |
| opnd_in | input | 4*DIGITS | Second operand B |
| result | output | 4*DIGITS | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| done | output | 1 | One-cycle pulse after a start |

## Verification
The hardest case is a decimal add in which the zero, negative and overflow flags disagree with the corrected result. An example is 0x99 + 0x01: the result is 0x00 but Z is clear, because the binary sum is 0x9A. Others are sums whose top digit crosses 8 before correction, which set N and V although the stored digit is small. Directed vectors are chosen for these cases, alongside digits above 9 that force double corrections. A strided sweep over both operands in all four modes and both carry values then compares each outcome with a digit-by-digit model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

   localparam int unsigned ASU_DIGIT_W   = 4;
   localparam int unsigned ASU_DIGIT_MAX = 9;
   localparam int unsigned ASU_FIXUP     = 6;

   typedef enum logic {
      ASU_ADD = 1'b0,
      ASU_SUB = 1'b1
   } asu_op_e;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } asu_flags_t;

endpackage

// File: rtl/addsub_bin.sv
module addsub_bin
   import addsub_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         op_sub,
   input  logic         cin,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output asu_flags_t   flags
);

   logic [W-1:0] b_eff;
   logic [W:0]   ext;

   always_comb begin
      b_eff = op_sub ? ~b : b;
      ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
      res   = ext[W-1:0];
      flags.c = ext[W];
      flags.v = ~(a[W-1] ^ b_eff[W-1]) & (a[W-1] ^ ext[W-1]);
      flags.n = ext[W-1];
      flags.z = (ext[W-1:0] == '0);
   end

endmodule

// File: rtl/addsub_bcd_add.sv
module addsub_bcd_add
   import addsub_pkg::*;
#(
   parameter int unsigned DIGITS = 2
) (
   input  logic                  cin,
   input  logic [4*DIGITS-1:0]   a,
   input  logic [4*DIGITS-1:0]   b,
   output logic [4*DIGITS-1:0]   res,
   output logic                  top_pre_n,
   output logic                  top_pre_v,
   output logic                  carry_out
);

   localparam int unsigned W     = DIGITS * ASU_DIGIT_W;
   localparam int unsigned SUM_W = ASU_DIGIT_W + 2;
   localparam logic [SUM_W-1:0] LIM_DEC = SUM_W'(ASU_DIGIT_MAX);
   localparam logic [SUM_W-1:0] LIM_HEX = SUM_W'((1 << ASU_DIGIT_W) - 1);
   localparam logic [SUM_W-1:0] FIX     = SUM_W'(ASU_FIXUP);

   logic [DIGITS:0]  cy;
   logic [SUM_W-1:0] raw_sum [DIGITS];

   assign cy[0] = cin;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [SUM_W-1:0] fixed;
      assign raw_sum[i] = SUM_W'(a[ASU_DIGIT_W*i +: ASU_DIGIT_W])
                        + SUM_W'(b[ASU_DIGIT_W*i +: ASU_DIGIT_W])
                        + SUM_W'(cy[i]);
      assign fixed      = (raw_sum[i] > LIM_DEC) ? raw_sum[i] + FIX : raw_sum[i];
      assign cy[i+1]    = (fixed > LIM_HEX);
      assign res[ASU_DIGIT_W*i +: ASU_DIGIT_W] = fixed[ASU_DIGIT_W-1:0];
   end

   assign top_pre_n = raw_sum[DIGITS-1][ASU_DIGIT_W-1];
   assign top_pre_v = (raw_sum[DIGITS-1][ASU_DIGIT_W-1] ^ a[W-1]) & ~(a[W-1] ^ b[W-1]);
   assign carry_out = cy[DIGITS];

endmodule

// File: rtl/addsub_bcd_sub.sv
module addsub_bcd_sub
   import addsub_pkg::*;
#(
   parameter int unsigned DIGITS = 2
) (
   input  logic                  cin,
   input  logic [4*DIGITS-1:0]   a,
   input  logic [4*DIGITS-1:0]   b,
   output logic [4*DIGITS-1:0]   res
);

   localparam int unsigned DIF_W = ASU_DIGIT_W + 1;
   localparam logic [DIF_W-1:0] FIX = DIF_W'(ASU_FIXUP);

   logic [DIGITS:0] bw;

   assign bw[0] = ~cin;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [DIF_W-1:0] raw_dif;
      logic [DIF_W-1:0] fixed;
      assign raw_dif = {1'b0, a[ASU_DIGIT_W*i +: ASU_DIGIT_W]}
                     - {1'b0, b[ASU_DIGIT_W*i +: ASU_DIGIT_W]}
                     - DIF_W'(bw[i]);
      assign fixed   = raw_dif[DIF_W-1] ? raw_dif - FIX : raw_dif;
      assign bw[i+1] = raw_dif[DIF_W-1];
      assign res[ASU_DIGIT_W*i +: ASU_DIGIT_W] = fixed[ASU_DIGIT_W-1:0];
   end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
   import addsub_pkg::*;
#(
   parameter int unsigned DIGITS     = 2,
   parameter int unsigned DEC_ENABLE = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  op_sub,
   input  logic                  dec_mode,
   input  logic                  carry_in,
   input  logic [4*DIGITS-1:0]   acc_in,
   input  logic [4*DIGITS-1:0]   opnd_in,
   output logic [4*DIGITS-1:0]   result,
   output logic                  flag_n,
   output logic                  flag_v,
   output logic                  flag_z,
   output logic                  flag_c,
   output logic                  done
);

   localparam int unsigned W = DIGITS * ASU_DIGIT_W;

   if (DIGITS < 1) begin : g_bad_digits
      $error("addsub_unit: DIGITS must be at least 1");
   end
   if (DEC_ENABLE > 1) begin : g_bad_dec
      $error("addsub_unit: DEC_ENABLE must be 0 or 1");
   end

   logic [W-1:0] bin_res;
   asu_flags_t   bin_flags;
   logic [W-1:0] nxt_res;
   asu_flags_t   nxt_flags;
   asu_flags_t   flags_q;

   addsub_bin #(.W(W)) u_bin (
      .op_sub (op_sub),
      .cin    (carry_in),
      .a      (acc_in),
      .b      (opnd_in),
      .res    (bin_res),
      .flags  (bin_flags)
   );

   if (DEC_ENABLE == 1) begin : g_dec
      logic [W-1:0] dadd_res;
      logic [W-1:0] dsub_res;
      logic         dadd_n;
      logic         dadd_v;
      logic         dadd_c;

      addsub_bcd_add #(.DIGITS(DIGITS)) u_dadd (
         .cin       (carry_in),
         .a         (acc_in),
         .b         (opnd_in),
         .res       (dadd_res),
         .top_pre_n (dadd_n),
         .top_pre_v (dadd_v),
         .carry_out (dadd_c)
      );

      addsub_bcd_sub #(.DIGITS(DIGITS)) u_dsub (
         .cin (carry_in),
         .a   (acc_in),
         .b   (opnd_in),
         .res (dsub_res)
      );

      always_comb begin
         nxt_res   = bin_res;
         nxt_flags = bin_flags;
         if (dec_mode) begin
            if (asu_op_e'(op_sub) == ASU_SUB) begin
               nxt_res = dsub_res;
            end else begin
               nxt_res     = dadd_res;
               nxt_flags.n = dadd_n;
               nxt_flags.v = dadd_v;
               nxt_flags.c = dadd_c;
            end
         end
      end
   end else begin : g_bin_only
      logic unused_dec;
      assign unused_dec = dec_mode;
      always_comb begin
         nxt_res   = bin_res;
         nxt_flags = bin_flags;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result  <= '0;
         flags_q <= '0;
         done    <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            result  <= nxt_res;
            flags_q <= nxt_flags;
         end
      end
   end

   assign flag_n = flags_q.n;
   assign flag_v = flags_q.v;
   assign flag_z = flags_q.z;
   assign flag_c = flags_q.c;

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         op_sub,
   input logic         dec_mode,
   input logic         carry_in,
   input logic [W-1:0] acc_in,
   input logic [W-1:0] opnd_in,
   input logic [W-1:0] result,
   input logic         flag_n,
   input logic         flag_v,
   input logic         flag_z,
   input logic         flag_c,
   input logic         done
);

   logic [W-1:0] cap_a;
   logic [W-1:0] cap_b;
   logic         cap_c;
   logic [W:0]   cap_sum;
   logic [W:0]   cap_need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a <= '0;
         cap_b <= '0;
         cap_c <= 1'b0;
      end else if (start) begin
         cap_a <= acc_in;
         cap_b <= opnd_in;
         cap_c <= carry_in;
      end
   end

   assign cap_sum  = {1'b0, cap_a} + {1'b0, cap_b} + {{W{1'b0}}, cap_c};
   assign cap_need = {1'b0, cap_b} + {{W{1'b0}}, ~cap_c};

   // R2
   done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);

   // R2
   done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));

   // R2
   outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result) && $stable({flag_n, flag_v, flag_z, flag_c})));

   // R4
   bin_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !dec_mode) |=> ((flag_z == (result == '0)) && (flag_n == result[W-1])));

   // R8
   dec_add_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && dec_mode && !op_sub) |=> (flag_z == (cap_sum[W-1:0] == '0)));

   // R10
   sub_no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sub) |=> (flag_c == ({1'b0, cap_a} >= cap_need)));

endmodule

bind addsub_unit addsub_unit_chk #(.W(DIGITS * 4)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .op_sub   (op_sub),
   .dec_mode (dec_mode),
   .carry_in (carry_in),
   .acc_in   (acc_in),
   .opnd_in  (opnd_in),
   .result   (result),
   .flag_n   (flag_n),
   .flag_v   (flag_v),
   .flag_z   (flag_z),
   .flag_c   (flag_c),
   .done     (done)
);

// File: tb/addsub_unit_test.sv
`timescale 1ns/1ps
module addsub_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       op_sub = 1'b0;
   logic       dec_mode = 1'b0;
   logic       carry_in = 1'b0;
   logic [7:0] acc_in = 8'h00;
   logic [7:0] opnd_in = 8'h00;
   logic [7:0] result;
   logic       flag_n, flag_v, flag_z, flag_c, done;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   addsub_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
      .dec_mode(dec_mode), .carry_in(carry_in), .acc_in(acc_in),
      .opnd_in(opnd_in), .result(result), .flag_n(flag_n),
      .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .done(done)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Reference built from the requirement text, digit by digit on integers.
   task automatic model(input bit sub, input bit dec, input int a, input int b, input bit c,
                        output int res, output bit n, output bit v, output bit z, output bit cf);
      int t, lo, hi;
      if (!sub) begin
         t  = a + b + c;
         res = t & 255;
         cf = (t > 255);
         v  = (((a ^ b) & 128) == 0) && (((a ^ t) & 128) != 0);
         n  = res[7];
         z  = (res == 0);
         if (dec) begin
            lo = (a & 15) + (b & 15) + c;
            if (lo > 9) lo += 6;
            hi = (a >> 4) + (b >> 4) + ((lo > 15) ? 1 : 0);
            n  = hi[3];
            v  = ((hi[3] != a[7])) && (((a ^ b) & 128) == 0);
            if (hi > 9) hi += 6;
            cf = (hi > 15);
            res = ((hi << 4) | (lo & 15)) & 255;
         end
      end else begin
         t  = a - b - (1 - c);
         res = t & 255;
         cf = (t >= 0);
         v  = (((a ^ t) & 128) != 0) && (((a ^ b) & 128) != 0);
         n  = res[7];
         z  = (res == 0);
         if (dec) begin
            lo = (a & 15) - (b & 15) - (1 - c);
            hi = (a >> 4) - (b >> 4);
            if ((lo & 16) != 0) begin lo -= 6; hi -= 1; end
            if ((hi & 16) != 0) hi -= 6;
            res = ((hi << 4) | (lo & 15)) & 255;
         end
      end
   endtask

   task automatic apply(input string tag, input bit sub, input bit dec,
                        input int a, input int b, input bit c);
      int res; bit n, v, z, cf;
      model(sub, dec, a, b, c, res, n, v, z, cf);
      @(negedge clk);
      op_sub = sub; dec_mode = dec; carry_in = c;
      acc_in = 8'(a); opnd_in = 8'(b); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(tag, "result", int'(result), res);
      chk(tag, "N", int'(flag_n), int'(n));
      chk(tag, "V", int'(flag_v), int'(v));
      chk(tag, "Z", int'(flag_z), int'(z));
      chk(tag, "C", int'(flag_c), int'(cf));
      chk("R2", "done", int'(done), 1);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "result in reset", int'(result), 0);
      chk("R1", "flags in reset", int'({flag_n, flag_v, flag_z, flag_c}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "result after reset", int'(result), 0);
      chk("R1", "flags after reset", int'({flag_n, flag_v, flag_z, flag_c}), 0);
      chk("R1", "done after reset", int'(done), 0);
   endtask

   task automatic t_hold();
      logic [7:0] keep_r; logic [3:0] keep_f;
      apply("R3", 1'b0, 1'b0, 8'h12, 8'h34, 1'b1);
      keep_r = result;
      keep_f = {flag_n, flag_v, flag_z, flag_c};
      acc_in = 8'hFF; opnd_in = 8'h80; op_sub = 1'b1; dec_mode = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R2", "done without start", int'(done), 0);
         chk("R2", "result hold", int'(result), int'(keep_r));
         chk("R2", "flags hold", int'({flag_n, flag_v, flag_z, flag_c}), int'(keep_f));
      end
   endtask

   task automatic t_bin_add();
      apply("R3", 1'b0, 1'b0, 8'hFF, 8'h01, 1'b0);
      apply("R3", 1'b0, 1'b0, 8'hFF, 8'hFF, 1'b1);
      apply("R4", 1'b0, 1'b0, 8'h50, 8'h50, 1'b0);
      apply("R4", 1'b0, 1'b0, 8'h80, 8'h80, 1'b0);
      apply("R4", 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
   endtask

   task automatic t_bin_sub();
      apply("R5", 1'b1, 1'b0, 8'h00, 8'h01, 1'b1);
      apply("R5", 1'b1, 1'b0, 8'h05, 8'h05, 1'b0);
      apply("R5", 1'b1, 1'b0, 8'h05, 8'h05, 1'b1);
      apply("R5", 1'b1, 1'b0, 8'h50, 8'hB0, 1'b1);
      apply("R5", 1'b1, 1'b0, 8'h80, 8'h01, 1'b1);
   endtask

   task automatic t_dec_add();
      apply("R6", 1'b0, 1'b1, 8'h09, 8'h01, 1'b0);
      apply("R6", 1'b0, 1'b1, 8'h58, 8'h46, 1'b1);
      apply("R7", 1'b0, 1'b1, 8'h99, 8'h01, 1'b0);
      apply("R7", 1'b0, 1'b1, 8'h50, 8'h50, 1'b0);
      apply("R8", 1'b0, 1'b1, 8'h79, 8'h00, 1'b1);
      apply("R8", 1'b0, 1'b1, 8'h99, 8'h67, 1'b0);
   endtask

   task automatic t_dec_sub();
      apply("R9", 1'b1, 1'b1, 8'h10, 8'h01, 1'b1);
      apply("R9", 1'b1, 1'b1, 8'h00, 8'h01, 1'b1);
      apply("R9", 1'b1, 1'b1, 8'h46, 8'h12, 1'b0);
      apply("R10", 1'b1, 1'b1, 8'h32, 8'h32, 1'b1);
      apply("R10", 1'b1, 1'b1, 8'h20, 8'h90, 1'b1);
   endtask

   task automatic t_invalid();
      apply("R11", 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1);
      apply("R11", 1'b0, 1'b1, 8'h0A, 8'h0B, 1'b0);
      apply("R11", 1'b1, 1'b1, 8'hAA, 8'h0F, 1'b1);
      apply("R11", 1'b1, 1'b1, 8'h0C, 8'hFD, 1'b0);
   endtask

   task automatic t_sweep();
      for (int a = 0; a < 256; a += 7) begin
         for (int b = 0; b < 256; b += 11) begin
            for (int m = 0; m < 8; m++) begin
               case (m[2:1])
                  2'd0: apply("R3", m[2], m[1], a, b, m[0]);
                  2'd1: apply("R6", 1'b0, 1'b1, a, b, m[0]);
                  2'd2: apply("R5", 1'b1, 1'b0, a, b, m[0]);
                  default: apply("R9", 1'b1, 1'b1, a, b, m[0]);
               endcase
            end
         end
      end
   endtask

   initial begin
      t_reset();
      t_hold();
      t_bin_add();
      t_bin_sub();
      t_dec_add();
      t_dec_sub();
      t_invalid();
      t_sweep();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule